// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Modulator with Distributed Mode

This block drives two output pins from two independent pulse-width channels, programmed through a small 32-bit memory-mapped register file. The bus is a plain single-cycle interface: an address, a write strobe, write data, and combinational read data. Each channel has a period length (the range) and a high-tick count (the data). A single clock-enable input, `tick`, sets the rate at which both channels advance.

Each channel runs in one of two ways. In grouped mode it produces an ordinary duty-cycle waveform: the high ticks come first as one run, then the low ticks. In distributed mode it keeps the same ratio of high ticks to total ticks, but an accumulator spreads the high ticks as evenly as it can across the period. A single control word holds, per channel, an enable, an output invert, an idle level, and the mode select. A disabled channel parks its pin at its idle level.

Top module: `duo_pwm`

## Requirements
- R1: After reset, both pins are 0 and every register reads 0.
- R2: Channel 0 range and data are at byte addresses 0x10 and 0x14, and channel 1 range and data are at 0x20 and 0x24. These read back what was last written, zero-extended from CNT_W bits. Any other address except 0x00 reads 0.
- R3: The control word at 0x00 has this layout for channel 0: enable at bit 0, idle level at bit 3, invert at bit 4, grouped mode at bit 7. Channel 1 uses the same layout shifted by 8 bits. Every other bit, including bits 6 and 14, reads 0.
- R4: In grouped mode, with range R and data D where 0<D<R, the pin is high for the first D ticks of each R-tick period and low for the rest.
- R5: In distributed mode, each tick adds D to an accumulator. If the sum reaches R or more, R is subtracted and the pin is high for that tick; otherwise the pin is low.
- R6: In either mode, D>=R with R>0 keeps the active pin high on every tick. D=0 or R=0 keeps it low.
- R7: Setting a channel's invert bit inverts its active output.
- R8: A disabled channel drives its idle bit on its pin, whatever its invert bit and `tick` are.
- R9: Writing 0 to the control word disables both channels in the next cycle.
- R10: In grouped mode, a range or data value written mid-period takes effect only at the start of the next period.
- R11: Enabling a channel restarts its period counter and accumulator from zero.
- R12: A channel's state and pin change only on cycles where `tick` is 1, apart from enable changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | PWM step enable |
| addr | input | ADDR_W | Byte address of register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | BUS_W | Write data |
| rd_data | output | BUS_W | Read data for `addr` (combinational) |
| pwm_out | output | NCH | One output pin per channel |

## Verification
The hardest case to reach is a range or data update that arrives partway through a grouped-mode period. The bench must separate an update taken on the next tick from one held back until the period wraps. To do this, it steps the channel by a known number of ticks, rewrites the data mid-period, and scores every following tick against the old value until the wrap and the new value after it. A restart is exercised the same way: the enable is toggled while the counter is mid-period, so a channel that failed to clear would continue with a visibly shifted pattern.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
   // control-word bit positions within one channel's byte
   localparam int CTL_EN     = 0;
   localparam int CTL_IDLE   = 3;
   localparam int CTL_INV    = 4;
   localparam int CTL_MS     = 7;
   localparam int CTL_STRIDE = 8;

   // byte addresses
   localparam int OFS_CTRL    = 'h00;
   localparam int OFS_RNG0    = 'h10;
   localparam int OFS_DAT0    = 'h14;
   localparam int CH_OFS_STEP = 'h10;

   typedef struct packed {
      logic ms;
      logic inv;
      logic idle;
      logic en;
   } chan_cfg_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
   import pwm_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 8,
   parameter int BUS_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [BUS_W-1:0]  wr_data,
   output logic [BUS_W-1:0]  rd_data,
   output chan_cfg_t         cfg_o [NCH],
   output logic [CNT_W-1:0]  rng_o [NCH],
   output logic [CNT_W-1:0]  dat_o [NCH]
);

   generate
      if (NCH * CTL_STRIDE > BUS_W) begin : g_bad_nch
         $error("pwm_regs: control word too narrow for NCH");
      end
      if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt
         $error("pwm_regs: CNT_W out of range");
      end
      if (OFS_DAT0 + NCH * CH_OFS_STEP > (1 << ADDR_W)) begin : g_bad_addr
         $error("pwm_regs: ADDR_W too small for map");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            cfg_o[i] <= '0;
            rng_o[i] <= '0;
            dat_o[i] <= '0;
         end
      end else if (wr_en) begin
         for (int i = 0; i < NCH; i++) begin
            if (addr == ADDR_W'(OFS_CTRL)) begin
               cfg_o[i] <= '{ms:   wr_data[i*CTL_STRIDE + CTL_MS],
                              inv:  wr_data[i*CTL_STRIDE + CTL_INV],
                              idle: wr_data[i*CTL_STRIDE + CTL_IDLE],
                              en:   wr_data[i*CTL_STRIDE + CTL_EN]};
            end
            if (addr == ADDR_W'(OFS_RNG0 + i*CH_OFS_STEP))
               rng_o[i] <= wr_data[CNT_W-1:0];
            if (addr == ADDR_W'(OFS_DAT0 + i*CH_OFS_STEP))
               dat_o[i] <= wr_data[CNT_W-1:0];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NCH; i++) begin
         if (addr == ADDR_W'(OFS_CTRL)) begin
            rd_data[i*CTL_STRIDE + CTL_MS]   = cfg_o[i].ms;
            rd_data[i*CTL_STRIDE + CTL_INV]  = cfg_o[i].inv;
            rd_data[i*CTL_STRIDE + CTL_IDLE] = cfg_o[i].idle;
            rd_data[i*CTL_STRIDE + CTL_EN]   = cfg_o[i].en;
         end
         if (addr == ADDR_W'(OFS_RNG0 + i*CH_OFS_STEP))
            rd_data = BUS_W'(rng_o[i]);
         if (addr == ADDR_W'(OFS_DAT0 + i*CH_OFS_STEP))
            rd_data = BUS_W'(dat_o[i]);
      end
   end

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_chk
         // R9
         clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(OFS_CTRL) && wr_data == '0) |=> !cfg_o[g].en);
      end
   endgenerate

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
   import pwm_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter bit HAS_DIST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  chan_cfg_t        cfg,
   input  logic [CNT_W-1:0] rng_i,
   input  logic [CNT_W-1:0] dat_i,
   output logic             pin
);

   logic [CNT_W-1:0] cnt_q, acc_q, rng_a, dat_a;
   logic             level_q;
   logic             use_ms, wrap, ms_level;
   logic             d_level;
   logic [CNT_W-1:0] d_acc;

   // without the distributed variant every channel runs grouped
   assign use_ms   = cfg.ms | !HAS_DIST;
   assign wrap     = (rng_a == '0) || (cnt_q == rng_a - 1'b1);
   assign ms_level = (rng_a != '0) && (cnt_q < dat_a);

   generate
      if (HAS_DIST) begin : g_dist
         logic [CNT_W:0] sum;
         assign sum = {1'b0, acc_q} + {1'b0, dat_i};
         always_comb begin
            if (rng_i == '0 || dat_i == '0 || acc_q >= rng_i) begin
               d_level = 1'b0;
               d_acc   = '0;
            end else if (dat_i >= rng_i) begin
               d_level = 1'b1;
               d_acc   = '0;
            end else if (sum >= {1'b0, rng_i}) begin
               d_level = 1'b1;
               d_acc   = CNT_W'(sum - {1'b0, rng_i});
            end else begin
               d_level = 1'b0;
               d_acc   = sum[CNT_W-1:0];
            end
         end
      end else begin : g_no_dist
         assign d_level = 1'b0;
         assign d_acc   = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         acc_q   <= '0;
         rng_a   <= '0;
         dat_a   <= '0;
         level_q <= 1'b0;
      end else if (!cfg.en) begin
         cnt_q   <= '0;
         acc_q   <= '0;
         rng_a   <= rng_i;
         dat_a   <= dat_i;
         level_q <= 1'b0;
      end else if (tick) begin
         if (use_ms) begin
            level_q <= ms_level;
            acc_q   <= '0;
            if (wrap) begin
               cnt_q <= '0;
               rng_a <= rng_i;
               dat_a <= dat_i;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            level_q <= d_level;
            acc_q   <= d_acc;
            cnt_q   <= '0;
            rng_a   <= rng_i;
            dat_a   <= dat_i;
         end
      end
   end

   assign pin = cfg.en ? (level_q ^ cfg.inv) : cfg.idle;

   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.en && use_ms && rng_a != '0) |-> (cnt_q < rng_a));

   // R11
   restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg.en) |-> (cnt_q == '0 && acc_q == '0 && !level_q));

   // R12
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.en && !tick) |=> (!cfg.en || $stable(level_q)));

   // R6
   sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg.en && tick && !use_ms && rng_i != '0 && dat_i >= rng_i) |=>
         (!cfg.en || level_q));

endmodule

// File: rtl/duo_pwm.sv
module duo_pwm
   import pwm_pkg::*;
#(
   parameter int NCH      = 2,
   parameter int CNT_W    = 16,
   parameter int ADDR_W   = 8,
   parameter int BUS_W    = 32,
   parameter bit HAS_DIST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [BUS_W-1:0]  wr_data,
   output logic [BUS_W-1:0]  rd_data,
   output logic [NCH-1:0]    pwm_out
);

   chan_cfg_t        cfg [NCH];
   logic [CNT_W-1:0] rng [NCH];
   logic [CNT_W-1:0] dat [NCH];

   pwm_regs #(
      .NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BUS_W(BUS_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data),
      .cfg_o(cfg), .rng_o(rng), .dat_o(dat)
   );

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         pwm_chan #(.CNT_W(CNT_W), .HAS_DIST(HAS_DIST)) u_chan (
            .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(cfg[c]),
            .rng_i(rng[c]), .dat_i(dat[c]), .pin(pwm_out[c])
         );
      end
   endgenerate

endmodule

// File: tb/duo_pwm_test.sv
`timescale 1ns/100ps
module duo_pwm_test;
   logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wr_data = '0;
   wire  [31:0] rd_data;
   wire  [1:0]  pwm_out;

   int n_chk = 0, n_bad = 0;

   typedef struct {
      logic [1:0] exp;
      string      tag;
   } item_t;
   item_t q[$];

   always #2.5 clk = ~clk;

   duo_pwm uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .pwm_out(pwm_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      addr = a;
      #1 check(tag, rd_data, exp);
   endtask

   // driver: one tick, then queue the pin pair expected after it
   task automatic step(input logic [1:0] e, input string tag);
      item_t it;
      @(negedge clk);
      #0.5 tick = 1'b1;
      @(posedge clk);
      #1 tick = 1'b0;
      it.exp = e; it.tag = tag;
      q.push_back(it);
   endtask

   // monitor
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         check(it.tag, {30'd0, pwm_out}, {30'd0, it.exp});
      end
   end

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #500000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      report();
   end

   initial begin
      int acc;
      logic b;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      #1 check("R1 pins", {30'd0, pwm_out}, 32'd0);
      rd_chk(8'h00, 32'd0, "R1 ctrl");
      rd_chk(8'h24, 32'd0, "R1 dat1");

      // R3 control layout
      wr(8'h00, 32'hFFFF_FFFF);
      rd_chk(8'h00, 32'h0000_9999, "R3");
      wr(8'h00, 32'd0);
      rd_chk(8'h00, 32'd0, "R9 ctrl");

      // R2 map
      wr(8'h10, 32'h1234); wr(8'h14, 32'h56); wr(8'h20, 32'h9abc); wr(8'h24, 32'hde);
      rd_chk(8'h10, 32'h1234, "R2 rng0");
      rd_chk(8'h14, 32'h56,   "R2 dat0");
      rd_chk(8'h20, 32'h9abc, "R2 rng1");
      rd_chk(8'h24, 32'hde,   "R2 dat1");
      rd_chk(8'h04, 32'd0,    "R2 gap");
      rd_chk(8'h30, 32'd0,    "R2 gap");

      // R8 idle levels
      wr(8'h00, 32'h1818);
      #1 check("R8", {30'd0, pwm_out}, 32'd3);
      for (int k = 0; k < 3; k++) step(2'b11, "R8 tick");
      wr(8'h00, 32'h0810);
      #1 check("R8", {30'd0, pwm_out}, 32'd2);

      // R4 grouped, R=5 D=2
      wr(8'h00, 32'd0); wr(8'h10, 32'd5); wr(8'h14, 32'd2);
      wr(8'h00, 32'h81);
      for (int k = 0; k < 10; k++) step({1'b0, (k % 5) < 2}, "R4");

      // R7 invert
      wr(8'h00, 32'd0); wr(8'h00, 32'h91);
      #1 check("R7 pre", {30'd0, pwm_out}, 32'd1);
      for (int k = 0; k < 5; k++) step({1'b0, !((k % 5) < 2)}, "R7");

      // R9 clear both, ch1 saturated grouped (R6)
      wr(8'h00, 32'd0); wr(8'h20, 32'd3); wr(8'h24, 32'd3);
      wr(8'h00, 32'h8181);
      step(2'b11, "R6 grouped");
      wr(8'h00, 32'd0);
      #1 check("R9 pins", {30'd0, pwm_out}, 32'd0);
      rd_chk(8'h00, 32'd0, "R9 ctrl");

      // R5 distributed on ch1
      wr(8'h20, 32'd5); wr(8'h24, 32'd2); wr(8'h00, 32'h0100);
      acc = 0;
      for (int k = 0; k < 10; k++) begin
         acc += 2; b = (acc >= 5); if (b) acc -= 5;
         step({b, 1'b0}, "R5");
      end
      wr(8'h00, 32'd0); wr(8'h20, 32'd7); wr(8'h24, 32'd3); wr(8'h00, 32'h0100);
      acc = 0;
      for (int k = 0; k < 14; k++) begin
         acc += 3; b = (acc >= 7); if (b) acc -= 7;
         step({b, 1'b0}, "R5 r7");
      end

      // R6 saturation both modes
      wr(8'h00, 32'd0); wr(8'h10, 32'd3); wr(8'h14, 32'd5);
      wr(8'h20, 32'd4); wr(8'h24, 32'd4); wr(8'h00, 32'h0181);
      for (int k = 0; k < 4; k++) step(2'b11, "R6 high");
      wr(8'h00, 32'd0); wr(8'h14, 32'd0); wr(8'h20, 32'd0); wr(8'h00, 32'h0181);
      for (int k = 0; k < 4; k++) step(2'b00, "R6 low");

      // R10 mid-period update
      wr(8'h00, 32'd0); wr(8'h10, 32'd4); wr(8'h14, 32'd1); wr(8'h00, 32'h81);
      step(2'b01, "R10 old"); step(2'b00, "R10 old");
      wr(8'h14, 32'd3);
      rd_chk(8'h14, 32'd3, "R2 dat0 new");
      step(2'b00, "R10 held"); step(2'b00, "R10 held");
      step(2'b01, "R10 new"); step(2'b01, "R10 new");
      step(2'b01, "R10 new"); step(2'b00, "R10 new");

      // R11 restart mid-period
      step(2'b01, "R11 pre");
      wr(8'h00, 32'd0); wr(8'h00, 32'h81);
      step(2'b01, "R11"); step(2'b01, "R11"); step(2'b01, "R11"); step(2'b00, "R11");

      // R12 tick qualifier
      step(2'b01, "R12");
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         #1 check("R12 hold", {30'd0, pwm_out}, 32'd1);
      end
      step(2'b01, "R12"); step(2'b01, "R12"); step(2'b00, "R12");

      repeat (3) @(negedge clk);
      report();
   end
endmodule